// File: doc/BRIEF.md
# Filtered Branch Record Stack

This block keeps a short history of retired control transfers for performance profiling. Each retire strobe brings a branch that has already been classified. It carries a kind code, the privilege level at which it lands, source and target addresses, a misprediction flag and a two-bit speculation status. Branches that pass a software-written suppress filter are pushed onto a stack of `DEPTH` records. The newest record always sits at index 0, and older records move one slot deeper on every push. When the stack is full, the record in the deepest slot is lost.

Software reaches the block through a flat register port. The port gives access to two 64-bit words per record, a nine-bit suppress register, a two-bit control register and a read-only capacity register. In the suppress register a set bit blocks one privilege class or one branch kind. The control register holds a global recording enable and a freeze option. When the freeze option is on, recording stops as soon as the performance-monitor interrupt input goes high. Recording stays stopped until software writes the control register again.

Top module: `brec_stack`

## Requirements
- R1: After reset, every record word, the suppress register and the control register read as zero, and the capacity register reads `DEPTH`.
- R2: A strobe that is enabled, not frozen and not suppressed puts a record at index 0 on the next clock edge. The source word is {mispredict, five copies of address bit 57, address[57:0]}. The target word is {status[1:0], 1'b0, three copies of address bit 57, address[57:0]}.
- R3: Each push moves record i to slot i+1. The record in slot `DEPTH`-1 is discarded.
- R4: Kind codes 0..6 (conditional, relative call, indirect call, return, indirect jump, relative jump, far) are blocked by suppress bits 2..8 in that order. Kind code 7 is never recorded.
- R5: A branch landing at privilege 0 (`br_user`=0) is blocked by suppress bit 0. A branch landing above privilege 0 (`br_user`=1) is blocked by suppress bit 1.
- R6: While control bit 0 (enable) is clear, no record is pushed.
- R7: While control bit 1 (freeze) is set, a high `pmi` blocks recording in that same cycle. The block then stays frozen until the next write to the control register.
- R8: Record i has its source word at address 2*i and its target word at 2*i+1. The suppress register sits at `CSR_BASE` and keeps bits [8:0] only. The control register sits at `CSR_BASE`+1 and keeps bits [1:0]. The capacity register sits at `CSR_BASE`+2.
- R9: A write to a record word replaces that word, and the new value reads back from the next cycle. Writing zero to every record word clears the stack.
- R10: Reads of any other address return zero, including record addresses at 2*`DEPTH` and above. Writes to the capacity register have no effect.
- R11: The status pair {valid, spec} is stored unchanged in target bits [63:62]. Its codes are 00 no branch, 01 wrong-path speculative, 10 non-speculative and 11 correct-path speculative. Target bit 61 of a pushed record is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_fire | input | 1 | Retire strobe for one classified branch |
| br_kind | input | 3 | Branch kind code (0..6, 7 unused) |
| br_user | input | 1 | Landing privilege above 0 |
| br_src | input | 58 | Branch source address |
| br_dst | input | 58 | Branch target address |
| br_mispred | input | 1 | Branch was mispredicted |
| br_stat | input | 2 | Status pair {valid, spec} |
| pmi | input | 1 | Performance-monitor interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on address) |

## Verification
The bound checker covers the per-cycle rules on every edge. A suppressed kind or privilege leaves the top record unchanged. So do a cleared enable, a frozen state and an interrupt under the freeze option. Every push lands the incoming address and status at index 0 with bit 61 clear. Unmapped reads and the capacity read are checked as well. Only the directed scenarios can show the ordering across a full stack, the loss of the oldest record, how long a freeze lasts until the control write, the exact word layout with sign copies, and register write-back and clearing.

// File: rtl/brec_pkg.sv
package brec_pkg;
   localparam int WORD_W   = 64;
   localparam int VA_W     = 58;
   localparam int SUP_W    = 9;
   localparam int KIND_LSB = 2;

   typedef enum logic [2:0] {
      BK_COND  = 3'd0,
      BK_RCALL = 3'd1,
      BK_ICALL = 3'd2,
      BK_RET   = 3'd3,
      BK_IJMP  = 3'd4,
      BK_RJMP  = 3'd5,
      BK_FAR   = 3'd6,
      BK_NONE  = 3'd7
   } br_kind_e;

   function automatic logic [WORD_W-1:0] pack_src(input logic mis, input logic [VA_W-1:0] a);
      return {mis, {5{a[VA_W-1]}}, a};
   endfunction

   function automatic logic [WORD_W-1:0] pack_dst(input logic [1:0] st, input logic [VA_W-1:0] a);
      return {st, 1'b0, {3{a[VA_W-1]}}, a};
   endfunction
endpackage

// File: rtl/brec_filter.sv
module brec_filter
   import brec_pkg::*;
(
   input  logic [SUP_W-1:0] sup,
   input  logic [2:0]       kind,
   input  logic             user,
   output logic             pass
);
   logic [SUP_W:0] sup_ext;
   logic [3:0]     kidx;
   logic           kind_ok;
   logic           priv_ok;

   // Code 7 maps onto a constant-one top bit, so it is always blocked.
   assign sup_ext = {1'b1, sup};
   assign kidx    = 4'(kind) + 4'(KIND_LSB);
   assign kind_ok = !sup_ext[kidx];
   assign priv_ok = !sup[{3'b000, user}];
   assign pass    = kind_ok && priv_ok;
endmodule

// File: rtl/brec_store.sv
module brec_store
   import brec_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_src,
   input  logic [WORD_W-1:0] push_dst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_hi,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] src_q [DEPTH],
   output logic [WORD_W-1:0] dst_q [DEPTH]
);
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [WORD_W-1:0] src_in, dst_in;
      logic              hit;

      if (g == 0) begin : g_head
         assign src_in = push_src;
         assign dst_in = push_dst;
      end else begin : g_tail
         assign src_in = src_q[g-1];
         assign dst_in = dst_q[g-1];
      end

      assign hit = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_q[g] <= '0;
            dst_q[g] <= '0;
         end else begin
            if (push) begin
               src_q[g] <= src_in;
               dst_q[g] <= dst_in;
            end
            // A register write wins over a push in the same cycle.
            if (hit && !wr_hi) src_q[g] <= wr_data;
            if (hit &&  wr_hi) dst_q[g] <= wr_data;
         end
      end
   end
endmodule

// File: rtl/brec_csr.sv
module brec_csr
   import brec_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 8,
   parameter int CSR_BASE = 'h80,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int REC_WORDS = 2 * DEPTH
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              pmi,
   input  logic [WORD_W-1:0] src_q [DEPTH],
   input  logic [WORD_W-1:0] dst_q [DEPTH],
   output logic [SUP_W-1:0]  sup_q,
   output logic              en_q,
   output logic              frz_en_q,
   output logic              frozen_q,
   output logic              rec_wr,
   output logic [IDX_W-1:0]  rec_idx,
   output logic              rec_hi,
   output logic [WORD_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_SUP = ADDR_W'(CSR_BASE);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CSR_BASE + 1);
   localparam logic [ADDR_W-1:0] A_CAP = ADDR_W'(CSR_BASE + 2);

   logic in_rec;

   assign in_rec  = addr < ADDR_W'(REC_WORDS);
   assign rec_idx = addr[IDX_W:1];
   assign rec_hi  = addr[0];
   assign rec_wr  = we && in_rec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sup_q    <= '0;
         en_q     <= 1'b0;
         frz_en_q <= 1'b0;
         frozen_q <= 1'b0;
      end else begin
         if (we && addr == A_SUP) sup_q <= wdata[SUP_W-1:0];
         if (we && addr == A_CTL) begin
            en_q     <= wdata[0];
            frz_en_q <= wdata[1];
            frozen_q <= 1'b0;
         end else if (frz_en_q && pmi) begin
            frozen_q <= 1'b1;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (in_rec)             rdata = rec_hi ? dst_q[rec_idx] : src_q[rec_idx];
      else if (addr == A_SUP) rdata = WORD_W'(sup_q);
      else if (addr == A_CTL) rdata = WORD_W'({frz_en_q, en_q});
      else if (addr == A_CAP) rdata = WORD_W'(DEPTH);
   end
endmodule

// File: rtl/brec_stack.sv
module brec_stack
   import brec_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 8,
   parameter int CSR_BASE = 'h80
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              br_fire,
   input  logic [2:0]        br_kind,
   input  logic              br_user,
   input  logic [VA_W-1:0]   br_src,
   input  logic [VA_W-1:0]   br_dst,
   input  logic              br_mispred,
   input  logic [1:0]        br_stat,
   input  logic              pmi,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("brec_stack: DEPTH must be at least 2");
   end
   if (2 * DEPTH > CSR_BASE) begin : g_bad_map
      $error("brec_stack: record words overlap the control registers");
   end
   if (CSR_BASE + 2 >= (1 << ADDR_W)) begin : g_bad_addr
      $error("brec_stack: ADDR_W too narrow for the register map");
   end

   logic [WORD_W-1:0] src_q [DEPTH];
   logic [WORD_W-1:0] dst_q [DEPTH];
   logic [SUP_W-1:0]  sup_q;
   logic              en_q, frz_en_q, frozen_q;
   logic              rec_wr, rec_hi;
   logic [IDX_W-1:0]  rec_idx;
   logic              pass, cap;

   brec_filter u_filter (
      .sup  (sup_q),
      .kind (br_kind),
      .user (br_user),
      .pass (pass)
   );

   assign cap = br_fire && pass && en_q && !frozen_q && !(frz_en_q && pmi);

   brec_store #(.DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (cap),
      .push_src (pack_src(br_mispred, br_src)),
      .push_dst (pack_dst(br_stat, br_dst)),
      .wr_en    (rec_wr),
      .wr_idx   (rec_idx),
      .wr_hi    (rec_hi),
      .wr_data  (reg_wdata),
      .src_q    (src_q),
      .dst_q    (dst_q)
   );

   brec_csr #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CSR_BASE(CSR_BASE)) u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .pmi      (pmi),
      .src_q    (src_q),
      .dst_q    (dst_q),
      .sup_q    (sup_q),
      .en_q     (en_q),
      .frz_en_q (frz_en_q),
      .frozen_q (frozen_q),
      .rec_wr   (rec_wr),
      .rec_idx  (rec_idx),
      .rec_hi   (rec_hi),
      .rdata    (reg_rdata)
   );
endmodule

// File: rtl/brec_stack_chk.sv
module brec_stack_chk
   import brec_pkg::*;
#(
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 8,
   parameter int CSR_BASE = 'h80
)(
   input logic              clk,
   input logic              rst_n,
   input logic              br_fire,
   input logic [2:0]        br_kind,
   input logic              br_user,
   input logic [VA_W-1:0]   br_dst,
   input logic [VA_W-1:0]   br_src,
   input logic [1:0]        br_stat,
   input logic              pmi,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [WORD_W-1:0] reg_rdata,
   input logic              cap,
   input logic [SUP_W-1:0]  sup_q,
   input logic              en_q,
   input logic              frz_en_q,
   input logic              frozen_q,
   input logic [WORD_W-1:0] top_src,
   input logic [WORD_W-1:0] top_dst
);
   logic [SUP_W:0] sup_ext;
   logic [3:0]     kidx;
   logic           unmapped;

   assign sup_ext  = {1'b1, sup_q};
   assign kidx     = 4'(br_kind) + 4'(KIND_LSB);
   assign unmapped = (reg_addr >= ADDR_W'(2 * DEPTH)) && (reg_addr < ADDR_W'(CSR_BASE) ||
                     reg_addr > ADDR_W'(CSR_BASE + 2));

   AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !reg_we) |=> (top_src[VA_W-1:0] == $past(br_src)) &&
                           (top_dst[VA_W-1:0] == $past(br_dst))); // R2

   AST_STATUS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !reg_we) |=> (top_dst[63:62] == $past(br_stat)) && !top_dst[61]); // R11

   AST_KIND_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (br_fire && !reg_we && sup_ext[kidx]) |=> $stable(top_src) && $stable(top_dst)); // R4

   AST_PRIV_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (br_fire && !reg_we && sup_q[{3'b000, br_user}]) |=> $stable(top_src) && $stable(top_dst)); // R5

   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !reg_we) |=> $stable(top_src) && $stable(top_dst)); // R6

   AST_PMI_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_en_q && pmi && !reg_we) |=> $stable(top_src) && $stable(top_dst) && frozen_q); // R7

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (frozen_q && !reg_we) |=> $stable(top_src) && $stable(top_dst)); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (reg_rdata == '0)); // R10

   AST_CAPACITY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(CSR_BASE + 2)) |-> (reg_rdata == WORD_W'(DEPTH))); // R8
endmodule

bind brec_stack brec_stack_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CSR_BASE(CSR_BASE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .br_fire   (br_fire),
   .br_kind   (br_kind),
   .br_user   (br_user),
   .br_dst    (br_dst),
   .br_src    (br_src),
   .br_stat   (br_stat),
   .pmi       (pmi),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .cap       (cap),
   .sup_q     (sup_q),
   .en_q      (en_q),
   .frz_en_q  (frz_en_q),
   .frozen_q  (frozen_q),
   .top_src   (src_q[0]),
   .top_dst   (dst_q[0])
);

// File: tb/brec_stack_tb_top.sv
`timescale 1ns/1ps
module brec_stack_tb_top;
   localparam int DEPTH = 16;
   localparam int AW    = 8;
   localparam logic [AW-1:0] A_SUP = 8'h80;
   localparam logic [AW-1:0] A_CTL = 8'h81;
   localparam logic [AW-1:0] A_CAP = 8'h82;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_fire = 1'b0;
   logic [2:0]  br_kind = '0;
   logic        br_user = 1'b0;
   logic [57:0] br_src = '0;
   logic [57:0] br_dst = '0;
   logic        br_mispred = 1'b0;
   logic [1:0]  br_stat = '0;
   logic        pmi = 1'b0;
   logic        reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   brec_stack #(.DEPTH(DEPTH), .ADDR_W(AW), .CSR_BASE('h80)) dut_i (.*);

   function automatic logic [63:0] exp_src(input logic m, input logic [57:0] a);
      return {m, {5{a[57]}}, a};
   endfunction
   function automatic logic [63:0] exp_dst(input logic [1:0] s, input logic [57:0] a);
      return {s, 1'b0, {3{a[57]}}, a};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [63:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [63:0] exp);
      logic [63:0] v;
      rd(a, v);
      check(req, v, exp);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic push(input logic [2:0] k, input logic u, input logic [57:0] s,
                       input logic [57:0] d, input logic m, input logic [1:0] st);
      @(negedge clk);
      br_fire = 1'b1; br_kind = k; br_user = u; br_src = s; br_dst = d;
      br_mispred = m; br_stat = st;
      @(negedge clk);
      br_fire = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk("R1 src0", 8'h00, 64'h0);
      rd_chk("R1 dst15", 8'h1F, 64'h0);
      rd_chk("R1 sup", A_SUP, 64'h0);
      rd_chk("R1 ctl", A_CTL, 64'h0);
      rd_chk("R1 cap", A_CAP, 64'(DEPTH));
   endtask

   task automatic t_capture();
      logic [57:0] s, d;
      s = {1'b1, 57'h1234};
      d = {1'b0, 57'h5678};
      wr(A_CTL, 64'h1);
      rd_chk("R8 ctl", A_CTL, 64'h1);
      push(3'd0, 1'b1, s, d, 1'b1, 2'b01);
      rd_chk("R2 src sign copies", 8'h00, exp_src(1'b1, s));
      rd_chk("R11 dst status 01", 8'h01, exp_dst(2'b01, d));
      push(3'd6, 1'b0, 58'h100, {1'b1, 57'h9}, 1'b0, 2'b11);
      rd_chk("R11 dst status 11", 8'h01, exp_dst(2'b11, {1'b1, 57'h9}));
      rd_chk("R3 older moved to 1", 8'h02, exp_src(1'b1, s));
   endtask

   task automatic t_shift();
      for (int i = 1; i <= DEPTH; i++)
         push(3'd1, 1'b0, 58'(i), 58'(i + 'h40), 1'b0, 2'b10);
      rd_chk("R3 idx0 newest", 8'h00, exp_src(1'b0, 58'd16));
      rd_chk("R3 idx5", 8'h0A, exp_src(1'b0, 58'd11));
      rd_chk("R3 idx5 dst", 8'h0B, exp_dst(2'b10, 58'd11 + 58'h40));
      rd_chk("R3 idx15 oldest kept", 8'h1E, exp_src(1'b0, 58'd1));
   endtask

   task automatic t_kind();
      wr(A_SUP, 64'h20);
      push(3'd3, 1'b0, 58'hAA, 58'hBB, 1'b0, 2'b10);
      rd_chk("R4 return blocked", 8'h00, exp_src(1'b0, 58'd16));
      push(3'd1, 1'b0, 58'hCC, 58'hDD, 1'b0, 2'b10);
      rd_chk("R4 rel call passes", 8'h00, exp_src(1'b0, 58'hCC));
      wr(A_SUP, 64'h0);
      push(3'd7, 1'b0, 58'hEE, 58'hFF, 1'b0, 2'b10);
      rd_chk("R4 code 7 dropped", 8'h00, exp_src(1'b0, 58'hCC));
      wr(A_SUP, 64'h100);
      push(3'd6, 1'b1, 58'h11, 58'h22, 1'b0, 2'b10);
      rd_chk("R4 far blocked", 8'h00, exp_src(1'b0, 58'hCC));
      wr(A_SUP, 64'hFFFF);
      rd_chk("R8 sup keeps 9 bits", A_SUP, 64'h1FF);
   endtask

   task automatic t_priv();
      wr(A_SUP, 64'h2);
      push(3'd0, 1'b1, 58'h31, 58'h32, 1'b0, 2'b10);
      rd_chk("R5 user blocked", 8'h00, exp_src(1'b0, 58'hCC));
      push(3'd0, 1'b0, 58'h33, 58'h34, 1'b0, 2'b10);
      rd_chk("R5 kernel passes", 8'h00, exp_src(1'b0, 58'h33));
      wr(A_SUP, 64'h1);
      push(3'd0, 1'b0, 58'h35, 58'h36, 1'b0, 2'b10);
      rd_chk("R5 kernel blocked", 8'h00, exp_src(1'b0, 58'h33));
      wr(A_SUP, 64'h0);
   endtask

   task automatic t_enable();
      wr(A_CTL, 64'h0);
      push(3'd0, 1'b0, 58'h41, 58'h42, 1'b0, 2'b10);
      rd_chk("R6 disabled", 8'h00, exp_src(1'b0, 58'h33));
   endtask

   task automatic t_freeze();
      wr(A_CTL, 64'h1);
      pmi = 1'b1;
      push(3'd0, 1'b0, 58'h51, 58'h52, 1'b0, 2'b10);
      rd_chk("R7 pmi ignored without freeze", 8'h00, exp_src(1'b0, 58'h51));
      pmi = 1'b0;
      wr(A_CTL, 64'h3);
      pmi = 1'b1;
      push(3'd0, 1'b0, 58'h53, 58'h54, 1'b0, 2'b10);
      pmi = 1'b0;
      rd_chk("R7 same-cycle block", 8'h00, exp_src(1'b0, 58'h51));
      push(3'd0, 1'b0, 58'h55, 58'h56, 1'b0, 2'b10);
      rd_chk("R7 stays frozen", 8'h00, exp_src(1'b0, 58'h51));
      wr(A_CTL, 64'h3);
      push(3'd0, 1'b0, 58'h57, 58'h58, 1'b0, 2'b10);
      rd_chk("R7 resumed after ctl write", 8'h00, exp_src(1'b0, 58'h57));
   endtask

   task automatic t_write();
      wr(8'h07, 64'hDEAD_BEEF_0123_4567);
      rd_chk("R9 word replaced", 8'h07, 64'hDEAD_BEEF_0123_4567);
      for (int i = 0; i < 2 * DEPTH; i++) wr(8'(i), 64'h0);
      wr(A_SUP, 64'h0);
      for (int i = 0; i < 2 * DEPTH; i += 5) rd_chk("R9 cleared", 8'(i), 64'h0);
      rd_chk("R9 last cleared", 8'h1F, 64'h0);
   endtask

   task automatic t_unmapped();
      rd_chk("R10 just past stack", 8'h20, 64'h0);
      rd_chk("R10 past ctl", 8'h83, 64'h0);
      rd_chk("R10 top addr", 8'hFF, 64'h0);
      wr(A_CAP, 64'h5);
      rd_chk("R10 cap read-only", A_CAP, 64'(DEPTH));
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_capture();
            t_shift();
            t_kind();
            t_priv();
            t_enable();
            t_freeze();
            t_write();
            t_unmapped();
         end
         begin
            repeat (20000) @(negedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule